// File: doc/BRIEF.md
# Write Protection Gate for a 16K x 8 Nonvolatile Store

This block sits between a command decoder and a 16K x 8 nonvolatile array. It decides, one request at a time, whether a byte write may reach the array. It also keeps the protection status register, which the request interface reaches at the highest address of the 14-bit space (0x3FFF). The register holds three things. The first is a volatile write-enable latch. The second is a two-bit selector for the locked region. The third is a protect-enable bit that, together with the external write-protect pin, freezes the protection settings.

An accepted array write leaves the block one clock after the request as a write strobe with its address and data. A refused write is dropped silently and produces no strobe. Register writes never produce an array strobe. The register contents are always visible on a status output.

There are two active-low asynchronous resets. `rst_n` models a warm reset and clears only the volatile latch and the issue stage. `por_n` models a first power-up of the nonvolatile model and clears everything. Both are released through a two-stage synchronizer.

Top module: `wp_guard`

## Requirements
- R1: After both resets are released, the status output reads 0x00 and no array write strobe is raised.
- R2: A warm reset (`rst_n` low, `por_n` high) clears the latch (status bit 0) but keeps status bits 3:2 and bit 7. A power-up reset (`por_n` low) clears all of them.
- R3: An array write while the latch is clear is dropped, and `arr_we` stays low in the following cycle.
- R4: Every write to address 0x3FFF loads data bit 0 into the latch (status bit 0), whatever the pin and the protect-enable bit are.
- R5: Status bits 3:2 select the locked region. 00 locks nothing, 01 locks 0x3000 to 0x3FFF, 10 locks 0x2000 to 0x3FFF, and 11 locks the whole array.
- R6: An array write with the latch set and the address outside the locked region raises `arr_we` for exactly the next cycle, with that address and data on `arr_addr` and `arr_data`.
- R7: A write to 0x3FFF loads data bits 3:2 and 7 into status bits 3:2 and 7 only if the latch was set before that write. Otherwise those bits keep their value.
- R8: While `wp_pin` is high and status bit 7 is set, writes to 0x3FFF leave status bits 3:2 and 7 unchanged.
- R9: While `wp_pin` is low, a write to 0x3FFF with the latch set may clear status bit 7 and change bits 3:2.
- R10: A write to 0x3FFF never raises `arr_we`, and the region lock does not block it.
- R11: Status bits 1 and 6:4 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-up reset, active low, clears all protection state |
| rst_n | input | 1 | Warm reset, active low, clears the latch and the issue stage |
| wr_req | input | 1 | Write request valid for one cycle |
| wr_addr | input | 14 | Request address; 0x3FFF selects the status register |
| wr_data | input | 8 | Request data |
| wp_pin | input | 1 | External write-protect pin, high to protect |
| arr_we | output | 1 | Array write strobe, one cycle after an accepted request |
| arr_addr | output | 14 | Address of the accepted array write |
| arr_data | output | 8 | Data of the accepted array write |
| stat | output | 8 | Status register contents |

## Verification
The assertions assume three things about the inputs. `wp_pin` changes only synchronously with the clock. A request lasts exactly one cycle. Reset assertions are long enough for the synchronizer to settle. The stimulus drives every input just after the falling edge, holds each request for a single cycle, and keeps every reset low for several cycles before releasing it. The bench then waits out the synchronizer before it sends the next request.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  typedef enum logic [1:0] {
    LOCK_NONE = 2'b00,
    LOCK_QTR  = 2'b01,
    LOCK_HALF = 2'b10,
    LOCK_ALL  = 2'b11
  } lock_sel_e;

  // status register field positions
  localparam int WEL_BIT = 0;
  localparam int SEL_LO  = 2;
  localparam int PEN_BIT = 7;
  localparam int STAT_W  = 8;

  typedef struct packed {
    logic      pen;
    lock_sel_e sel;
    logic      wel;
  } prot_t;

endpackage

// File: rtl/wpg_rst_sync.sv
module wpg_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      srst_n <= meta_q;
    end
  end

endmodule

// File: rtl/wpg_region_dec.sv
module wpg_region_dec
  import wpg_pkg::*;
#(
  parameter int AW = 14
) (
  input  lock_sel_e        sel,
  input  logic [AW-1:0]    addr,
  output logic             hit
);

  localparam logic [AW-1:0] QTR_BASE  = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] HALF_BASE = {1'b1,  {(AW-1){1'b0}}};

  always_comb begin
    unique case (sel)
      LOCK_NONE: hit = 1'b0;
      LOCK_QTR:  hit = (addr >= QTR_BASE);
      LOCK_HALF: hit = (addr >= HALF_BASE);
      default:   hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/wpg_stat_reg.sv
module wpg_stat_reg
  import wpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      nv_rst_n,
  input  logic      reg_wr,
  input  logic      in_wel,
  input  lock_sel_e in_sel,
  input  logic      in_pen,
  input  logic      wp_pin,
  output prot_t     prot
);

  logic      wel_q, wel_d;
  lock_sel_e sel_q, sel_d;
  logic      pen_q, pen_d;
  logic      nv_open;
  logic      nv_en;

  // nonvolatile fields need the latch and no pin-qualified freeze
  assign nv_open = wel_q && !(wp_pin && pen_q);
  assign nv_en   = reg_wr && nv_open;

  always_comb begin
    wel_d = wel_q;
    sel_d = sel_q;
    pen_d = pen_q;
    if (reg_wr) wel_d = in_wel;
    if (nv_en) begin
      sel_d = in_sel;
      pen_d = in_pen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else if (reg_wr) wel_q <= wel_d;
  end

  always_ff @(posedge clk or negedge nv_rst_n) begin
    if (!nv_rst_n) begin
      sel_q <= LOCK_NONE;
      pen_q <= 1'b0;
    end else if (nv_en) begin
      sel_q <= sel_d;
      pen_q <= pen_d;
    end
  end

  assign prot = '{pen: pen_q, sel: sel_q, wel: wel_q};

  // R7
  nv_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
    (reg_wr && !wel_q) |=> (sel_q == $past(sel_q) && pen_q == $past(pen_q)));

  // R8
  pin_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
    (reg_wr && wp_pin && pen_q) |=> (sel_q == $past(sel_q) && pen_q == $past(pen_q)));

  // R4
  wel_load_chk: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
    reg_wr |=> (wel_q == $past(in_wel)));

endmodule

// File: rtl/wpg_issue.sv
module wpg_issue #(
  parameter int AW = 14,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          is_reg,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          wel,
  input  logic          locked,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data
);

  localparam logic [AW-1:0] REG_ADDR = '1;

  logic go_d;

  assign go_d = req && !is_reg && wel && !locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arr_we <= 1'b0;
    else        arr_we <= go_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arr_addr <= '0;
      arr_data <= '0;
    end else if (go_d) begin
      arr_addr <= addr;
      arr_data <= data;
    end
  end

  // R3
  wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> $past(wel));

  // R6
  region_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !$past(locked));

  // R10
  reg_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (arr_addr != REG_ADDR));

endmodule

// File: rtl/wp_guard.sv
module wp_guard
  import wpg_pkg::*;
#(
  parameter int AW = 14,
  parameter int DW = STAT_W
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          wp_pin,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_data,
  output logic [DW-1:0] stat
);

  localparam logic [AW-1:0] REG_ADDR = '1;

  logic  core_rst_n;
  logic  nv_rst_n;
  logic  is_reg;
  logic  reg_wr;
  logic  locked;
  prot_t prot;

  wpg_rst_sync u_core_sync (
    .clk    (clk),
    .arst_n (rst_n & por_n),
    .srst_n (core_rst_n)
  );

  wpg_rst_sync u_nv_sync (
    .clk    (clk),
    .arst_n (por_n),
    .srst_n (nv_rst_n)
  );

  assign is_reg = (wr_addr == REG_ADDR);
  assign reg_wr = wr_req && is_reg;

  wpg_stat_reg u_stat (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .nv_rst_n (nv_rst_n),
    .reg_wr   (reg_wr),
    .in_wel   (wr_data[WEL_BIT]),
    .in_sel   (lock_sel_e'(wr_data[SEL_LO +: 2])),
    .in_pen   (wr_data[PEN_BIT]),
    .wp_pin   (wp_pin),
    .prot     (prot)
  );

  wpg_region_dec #(.AW(AW)) u_region (
    .sel  (prot.sel),
    .addr (wr_addr),
    .hit  (locked)
  );

  wpg_issue #(.AW(AW), .DW(DW)) u_issue (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .req      (wr_req),
    .is_reg   (is_reg),
    .addr     (wr_addr),
    .data     (wr_data),
    .wel      (prot.wel),
    .locked   (locked),
    .arr_we   (arr_we),
    .arr_addr (arr_addr),
    .arr_data (arr_data)
  );

  always_comb begin
    stat                = '0;
    stat[WEL_BIT]       = prot.wel;
    stat[SEL_LO +: 2]   = prot.sel;
    stat[PEN_BIT]       = prot.pen;
  end

  // R1
  post_reset_idle_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(core_rst_n) |-> !arr_we);

endmodule

// File: tb/wp_guard_test.sv
`timescale 1ns/1ps
module wp_guard_test;

  logic        clk;
  logic        por_n, rst_n;
  logic        wr_req;
  logic [13:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wp_pin;
  logic        arr_we;
  logic [13:0] arr_addr;
  logic [7:0]  arr_data;
  logic [7:0]  stat;

  int vecs  = 0;
  int fails = 0;
  int cyc   = 0;

  typedef struct {
    int          due;
    logic        we;
    logic [13:0] addr;
    logic [7:0]  data;
    logic [7:0]  st;
    string       tag;
  } exp_t;

  exp_t sb[$];

  // bench model of the protection state
  logic       m_wel;
  logic [1:0] m_sel;
  logic       m_pen;

  wp_guard uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_req(wr_req),
    .wr_addr(wr_addr), .wr_data(wr_data), .wp_pin(wp_pin),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data), .stat(stat)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] m_stat();
    return {m_pen, 3'b000, m_sel, 1'b0, m_wel};
  endfunction

  function automatic logic m_locked(input logic [13:0] a);
    case (m_sel)
      2'b00:   return 1'b0;
      2'b01:   return a >= 14'h3000;
      2'b10:   return a >= 14'h2000;
      default: return 1'b1;
    endcase
  endfunction

  task automatic do_wr(input logic [13:0] a, input logic [7:0] d, input string tag);
    exp_t e;
    wr_req  = 1'b1;
    wr_addr = a;
    wr_data = d;
    e.due  = cyc + 1;
    e.addr = a;
    e.data = d;
    e.tag  = tag;
    if (a == 14'h3FFF) begin
      if (m_wel && !(wp_pin && m_pen)) begin
        m_sel = d[3:2];
        m_pen = d[7];
      end
      m_wel = d[0];
      e.we  = 1'b0;
    end else begin
      e.we = m_wel && !m_locked(a);
    end
    e.st = m_stat();
    sb.push_back(e);
    @(negedge clk);
    wr_req = 1'b0;
  endtask

  // monitor: compare as results come due
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      vecs++;
      if (arr_we !== e.we || stat !== e.st ||
          (e.we && (arr_addr !== e.addr || arr_data !== e.data))) begin
        fails++;
        $display("FAIL %s: we=%0b addr=%h data=%h stat=%h, expected we=%0b addr=%h data=%h stat=%h",
                 e.tag, arr_we, arr_addr, arr_data, stat, e.we, e.addr, e.data, e.st);
      end
    end
  end

  task automatic chk_now(input logic [7:0] st, input string tag);
    vecs++;
    if (stat !== st || arr_we !== 1'b0) begin
      fails++;
      $display("FAIL %s: stat=%h we=%0b, expected stat=%h we=0", tag, stat, arr_we, st);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b0; wr_req = 1'b0;
    wr_addr = '0; wr_data = '0; wp_pin = 1'b0;
    m_wel = 1'b0; m_sel = 2'b00; m_pen = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    settle();
    chk_now(8'h00, "R1");

    do_wr(14'h0100, 8'hA5, "R3");
    do_wr(14'h3FFF, 8'h01, "R4");
    do_wr(14'h0100, 8'h5A, "R6");

    // quarter lock
    do_wr(14'h3FFF, 8'h05, "R5");
    do_wr(14'h2FFF, 8'h11, "R5");
    do_wr(14'h3000, 8'h22, "R5");
    do_wr(14'h0000, 8'h33, "R6");
    // half lock
    do_wr(14'h3FFF, 8'h09, "R5");
    do_wr(14'h1FFF, 8'h44, "R5");
    do_wr(14'h2000, 8'h55, "R5");
    do_wr(14'h3FFE, 8'h66, "R5");
    // whole array lock; register still reachable
    do_wr(14'h3FFF, 8'h0D, "R5");
    do_wr(14'h0000, 8'h77, "R5");
    do_wr(14'h3FFF, 8'h0C, "R10");
    do_wr(14'h3FFF, 8'h01, "R7");
    do_wr(14'h3FFF, 8'h00, "R7");

    // pin-qualified freeze
    wp_pin = 1'b1;
    do_wr(14'h3FFF, 8'h01, "R4");
    do_wr(14'h3FFF, 8'h81, "R8");
    do_wr(14'h3FFF, 8'h85, "R8");
    do_wr(14'h3FFF, 8'h04, "R8");
    do_wr(14'h3FFF, 8'h01, "R4");
    do_wr(14'h3FFE, 8'h88, "R6");

    // pin released
    wp_pin = 1'b0;
    do_wr(14'h3FFF, 8'h05, "R9");
    do_wr(14'h3FFF, 8'hFF, "R11");
    do_wr(14'h3FFF, 8'h05, "R9");
    @(negedge clk);

    // warm reset keeps nonvolatile fields
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    m_wel = 1'b0;
    chk_now(8'h04, "R2");
    do_wr(14'h0010, 8'h99, "R3");

    // power-up reset clears everything
    @(negedge clk);
    por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    settle();
    m_wel = 1'b0; m_sel = 2'b00; m_pen = 1'b0;
    chk_now(8'h00, "R2");

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule